// File: doc/BRIEF.md
# Block-Lock Status Register Unit

This unit keeps the status byte of a small serial flash memory. Only the low three bits carry state: a lock code that picks one of eight protected address ranges. The upper five bits always read back as zero. A front end that has already recovered the serial clock passes in one strobe per rising SCK edge, together with the sampled data-in bit and the chip-select level. The unit groups these bits into bytes. It answers the read-status command by presenting the status byte one bit at a time. It accepts the program-status command and starts a timed nonvolatile update of the lock code when the frame is deselected.

A bit pointer selects the status bit on the output. The pointer steps on every strobe and wraps after eight bits, so the host can keep clocking and read the byte again and again. During any nonvolatile write, whether the status update made by this unit or an array program reported on `ext_wip`, every output bit is forced to one. The pointer keeps moving during that time, so once the write finishes the output shows the register bit at the pointer's current position. A combinational decoder turns the lock code into a veto for any array address, and the program sequencer uses that veto.

Top module: `blsr_unit`

## Requirements
- R1: After reset the lock code is 000. `wip`, `so_en` and `pgm_en_clr` are low, and `chk_locked` is low for every address.
- R2: A frame whose first byte is 0x05 raises `so_en` from the cycle after that byte completes until chip-select goes high. `so_bit` then presents the status byte MSB first: bits [7:3] are zero and bits [2:0] are the lock code.
- R3: In a read frame the status bit pointer advances by one on every strobe and wraps from bit 0 back to bit 7, so the byte repeats without limit.
- R4: While `wip` is high, `so_bit` is 1 in a read frame and the pointer keeps advancing. After `wip` falls, `so_bit` shows the status bit at the pointer's current position.
- R5: A program-status frame is accepted when its first byte is 0x01, it carries at least one data byte, and chip-select rises exactly on a byte boundary. In the cycle after chip-select rises, `wip` goes high for WR_CYCLES cycles. `pgm_en_clr` pulses during the last of those cycles, and the new lock code is in place from the cycle in which `wip` falls.
- R6: When a program-status frame carries several data bytes, only the last complete byte is written.
- R7: A program-status frame has no effect in any of these cases: `pgm_en` is low when the opcode completes; `wip` is high when the opcode completes or when chip-select rises; there is no data byte; or chip-select rises in the middle of a byte.
- R8: Data bits [7:3] of a program-status byte are discarded, and only bits [2:0] become the lock code.
- R9: `chk_locked` is the veto for `chk_addr` in a 512-byte array with 16-byte sectors. Code 0: no address. 1: 384..511. 2: 256..511. 3: every address. 4: 0..15. 5: 496..511. 6: 0..255. 7: 0..127.
- R10: A frame whose first byte is neither opcode keeps `so_en` low and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip-select level, low selects |
| sck_rise | input | 1 | One-cycle strobe per rising serial clock edge |
| si | input | 1 | Serial data bit sampled at the strobe |
| pgm_en | input | 1 | Program enable latch state |
| ext_wip | input | 1 | Array program cycle in progress |
| chk_addr | input | ADDR_W | Address queried by the program sequencer |
| so_bit | output | 1 | Current status output bit |
| so_en | output | 1 | Output valid, high during a read-status frame |
| wip | output | 1 | Any nonvolatile write in progress |
| pgm_en_clr | output | 1 | One-cycle request to clear the enable latch |
| chk_locked | output | 1 | Program veto for chk_addr |

## Verification
The bench builds the unit with WR_CYCLES=40, ADDR_W=9 and SECT_W=4. With these values a read frame started right after a status update spends its whole first byte under the forced-one rule and then crosses the end of the write partway through its second byte. The 9-bit address lets the bench sweep every address against each of the eight lock codes, so each range boundary is checked on both sides.

// File: rtl/blsr_pkg.sv
package blsr_pkg;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;

  typedef enum logic [1:0] {
    FM_IDLE  = 2'd0,
    FM_READ  = 2'd1,
    FM_WRITE = 2'd2,
    FM_SKIP  = 2'd3
  } frame_mode_e;
endpackage

// File: rtl/blsr_framer.sv
module blsr_framer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_rise,
  input  logic              si,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_val,
  output logic              first_byte,
  output logic              aligned
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic              seen_q, seen_d;
  logic              stb, last;

  always_comb begin
    stb    = sck_rise & ~cs_n;
    last   = (cnt_q == CNT_W'(BYTE_W - 1));
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    seen_d = seen_q;
    if (cs_n) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (stb) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
      sh_d  = {sh_q[BYTE_W-3:0], si};
      if (last) seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      seen_q <= seen_d;
    end
  end

  assign byte_vld   = stb & last;
  assign byte_val   = {sh_q, si};
  assign first_byte = ~seen_q;
  assign aligned    = (cnt_q == '0);
endmodule

// File: rtl/blsr_wtimer.sv
module blsr_wtimer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)             cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/blsr_lockdec.sv
module blsr_lockdec #(
  parameter int ADDR_W = 9,
  parameter int SECT_W = 4
) (
  input  logic [2:0]        lock_bits,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned QTR   = DEPTH / 4;
  localparam int unsigned HALF  = DEPTH / 2;
  localparam int unsigned SECT  = 1 << SECT_W;
  localparam int unsigned UPQ   = DEPTH - QTR;
  localparam int unsigned LASTS = DEPTH - SECT;

  int unsigned a;

  always_comb begin
    a = 32'(addr);
    case (lock_bits)
      3'd1:    locked = (a >= UPQ);
      3'd2:    locked = (a >= HALF);
      3'd3:    locked = 1'b1;
      3'd4:    locked = (a < SECT);
      3'd5:    locked = (a >= LASTS);
      3'd6:    locked = (a < HALF);
      3'd7:    locked = (a < QTR);
      default: locked = 1'b0;
    endcase
  end
endmodule

// File: rtl/blsr_unit.sv
module blsr_unit
  import blsr_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int SECT_W    = 4,
  parameter int WR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_rise,
  input  logic              si,
  input  logic              pgm_en,
  input  logic              ext_wip,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              so_bit,
  output logic              so_en,
  output logic              wip,
  output logic              pgm_en_clr,
  output logic              chk_locked
);
  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic       byte_vld, first_byte, aligned;
  logic [7:0] byte_val;
  logic       own_busy, wr_done, commit;

  blsr_framer #(.BYTE_W(8)) u_framer (
    .clk(clk), .rst_n(rst_i), .cs_n(cs_n), .sck_rise(sck_rise), .si(si),
    .byte_vld(byte_vld), .byte_val(byte_val),
    .first_byte(first_byte), .aligned(aligned)
  );

  blsr_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_i), .start(commit),
    .busy(own_busy), .done(wr_done)
  );

  frame_mode_e mode_q, mode_d;
  logic [2:0]  ptr_q, ptr_d;
  logic [2:0]  cand_q, cand_d;
  logic        cand_ok_q, cand_ok_d;
  logic [2:0]  pend_q, pend_d;
  logic [2:0]  bl_q, bl_d;
  logic        cs_q;
  logic        any_wip, cs_rise;
  logic [7:0]  status;

  always_comb begin
    any_wip   = own_busy | ext_wip;
    cs_rise   = cs_n & ~cs_q;
    commit    = cs_rise & (mode_q == FM_WRITE) & cand_ok_q & aligned & ~any_wip;
    mode_d    = mode_q;
    ptr_d     = ptr_q;
    cand_d    = cand_q;
    cand_ok_d = cand_ok_q;
    pend_d    = pend_q;
    bl_d      = bl_q;

    if (cs_n) begin
      mode_d    = FM_IDLE;
      cand_ok_d = 1'b0;
    end else if (byte_vld) begin
      if (first_byte) begin
        if (byte_val == OP_RD_STAT) begin
          mode_d = FM_READ;
          ptr_d  = 3'd0;
        end else if (byte_val == OP_WR_STAT && pgm_en && !any_wip) begin
          mode_d = FM_WRITE;
        end else begin
          mode_d = FM_SKIP;
        end
      end else if (mode_q == FM_WRITE) begin
        cand_d    = byte_val[2:0];
        cand_ok_d = 1'b1;
      end
    end

    if (mode_q == FM_READ && sck_rise && !cs_n) ptr_d = ptr_q + 3'd1;
    if (commit)  pend_d = cand_q;
    if (wr_done) bl_d   = pend_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mode_q    <= FM_IDLE;
      ptr_q     <= 3'd0;
      cand_q    <= 3'd0;
      cand_ok_q <= 1'b0;
      pend_q    <= 3'd0;
      bl_q      <= 3'd0;
      cs_q      <= 1'b1;
    end else begin
      mode_q    <= mode_d;
      ptr_q     <= ptr_d;
      cand_q    <= cand_d;
      cand_ok_q <= cand_ok_d;
      pend_q    <= pend_d;
      bl_q      <= bl_d;
      cs_q      <= cs_n;
    end
  end

  blsr_lockdec #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_lockdec (
    .lock_bits(bl_q), .addr(chk_addr), .locked(chk_locked)
  );

  assign status     = {5'b00000, bl_q};
  assign so_en      = (mode_q == FM_READ);
  assign so_bit     = any_wip | status[3'd7 - ptr_q];
  assign wip        = any_wip;
  assign pgm_en_clr = wr_done;
endmodule

// File: rtl/blsr_unit_chk.sv
module blsr_unit_chk (
  input logic       clk,
  input logic       rst_i,
  input logic       cs_n,
  input logic       sck_rise,
  input logic       so_en,
  input logic       so_bit,
  input logic       wip,
  input logic       pgm_en_clr,
  input logic       chk_locked,
  input logic [2:0] ptr,
  input logic [2:0] lock_bits,
  input logic       own_busy
);
  // R2: the five upper status bits read as zero when idle
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_i)
    (so_en && !wip && ptr < 3'd5) |-> !so_bit);

  // R4: forced ones during a nonvolatile write
  a_r4_busy_ones: assert property (@(posedge clk) disable iff (!rst_i)
    (so_en && wip) |-> so_bit);

  // R3: one pointer step per strobe, modulo eight
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_i)
    (so_en && sck_rise && !cs_n) |=> (ptr == $past(ptr) + 3'd1));

  // R5: clear pulse marks the final busy cycle
  a_r5_clr_last: assert property (@(posedge clk) disable iff (!rst_i)
    pgm_en_clr |=> !own_busy);

  // R5: a status write starts only on deselect
  a_r5_start_deselect: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(own_busy) |-> $past(cs_n));

  // R8: lock code changes only at the end of a write
  a_r8_code_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !pgm_en_clr |=> $stable(lock_bits));

  // R9: the all and none codes
  a_r9_all: assert property (@(posedge clk) disable iff (!rst_i)
    (lock_bits == 3'd3) |-> chk_locked);
  a_r9_none: assert property (@(posedge clk) disable iff (!rst_i)
    (lock_bits == 3'd0) |-> !chk_locked);
endmodule

bind blsr_unit blsr_unit_chk u_chk (
  .clk(clk), .rst_i(rst_i), .cs_n(cs_n), .sck_rise(sck_rise),
  .so_en(so_en), .so_bit(so_bit), .wip(wip), .pgm_en_clr(pgm_en_clr),
  .chk_locked(chk_locked), .ptr(ptr_q), .lock_bits(bl_q), .own_busy(own_busy)
);

// File: tb/blsr_unit_tb.sv
`timescale 1ns/1ps
module blsr_unit_tb;
  localparam int WRC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck_rise = 1'b0, si = 1'b0;
  logic       pgm_en = 1'b0, ext_wip = 1'b0;
  logic [8:0] chk_addr = '0;
  logic       so_bit, so_en, wip, pgm_en_clr, chk_locked;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, finished = 0;

  always #2 clk = ~clk;

  blsr_unit #(.ADDR_W(9), .SECT_W(4), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .si(si),
    .pgm_en(pgm_en), .ext_wip(ext_wip), .chk_addr(chk_addr),
    .so_bit(so_bit), .so_en(so_en), .wip(wip),
    .pgm_en_clr(pgm_en_clr), .chk_locked(chk_locked)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_lock(int code, int a);
    case (code)
      1: return int'(a >= 384);
      2: return int'(a >= 256);
      3: return 1;
      4: return int'(a < 16);
      5: return int'(a >= 496);
      6: return int'(a < 256);
      7: return int'(a < 128);
      default: return 0;
    endcase
  endfunction

  // behavioural reference model
  int rel = 0;
  int m_csq, m_cnt, m_sh, m_seen, m_mode, m_ptr, m_cand, m_candok, m_pend, m_bl, m_tmr;
  int clr_seen = 0;

  always @(posedge clk) begin
    int wipnow, csrise, commit, done, stb, bdone, bval;
    int n_mode, n_ptr, n_cand, n_candok, n_pend, n_bl;
    if (!rst_n) rel = 0;
    if (rel < 2) begin
      m_csq = 1; m_cnt = 0; m_sh = 0; m_seen = 0; m_mode = 0; m_ptr = 0;
      m_cand = 0; m_candok = 0; m_pend = 0; m_bl = 0; m_tmr = 0;
      if (rst_n) rel++;
    end else begin
      wipnow = int'(m_tmr != 0 || ext_wip);
      csrise = int'(cs_n && m_csq == 0);
      commit = int'(csrise && m_mode == 2 && m_candok && m_cnt == 0 && !wipnow);
      done   = int'(m_tmr == 1);
      stb    = int'(sck_rise && !cs_n);
      bdone  = int'(stb && m_cnt == 7);
      bval   = ((m_sh << 1) | int'(si)) & 255;
      n_mode = m_mode; n_ptr = m_ptr; n_cand = m_cand; n_candok = m_candok;
      n_pend = m_pend; n_bl = m_bl;
      if (cs_n) begin
        n_mode = 0; n_candok = 0;
      end else if (bdone) begin
        if (!m_seen) begin
          if (bval == 5) begin n_mode = 1; n_ptr = 0; end
          else if (bval == 1 && pgm_en && !wipnow) n_mode = 2;
          else n_mode = 3;
        end else if (m_mode == 2) begin
          n_cand = bval & 7; n_candok = 1;
        end
      end
      if (m_mode == 1 && stb) n_ptr = (m_ptr + 1) % 8;
      if (commit) n_pend = m_cand;
      if (done) begin n_bl = m_pend; clr_seen++; end
      m_tmr = commit ? WRC : (m_tmr > 0 ? m_tmr - 1 : 0);
      if (cs_n) begin m_cnt = 0; m_seen = 0; end
      else if (stb) begin
        m_sh = bval; m_cnt = (m_cnt + 1) % 8;
        if (bdone) m_seen = 1;
      end
      m_csq = int'(cs_n);
      m_mode = n_mode; m_ptr = n_ptr; m_cand = n_cand; m_candok = n_candok;
      m_pend = n_pend; m_bl = n_bl;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int ew, eso;
    if (cmp_on && !finished) begin
      ew = int'(m_tmr != 0 || ext_wip);
      chk("R5 wip", int'(wip), ew);
      chk("R10 so_en", int'(so_en), int'(m_mode == 1));
      chk("R5 pgm_en_clr", int'(pgm_en_clr), int'(m_tmr == 1));
      chk("R9 chk_locked", int'(chk_locked), ref_lock(m_bl, int'(chk_addr)));
      if (m_mode == 1) begin
        eso = ew ? 1 : ((m_bl >> (7 - m_ptr)) & 1);
        if (ew) chk("R4 so_bit", int'(so_bit), eso);
        else    chk("R3 so_bit", int'(so_bit), eso);
      end
    end
  end

  task automatic strobe(bit b);
    @(negedge clk); #1 si = b; sck_rise = 1'b1;
    @(negedge clk); #1 sck_rise = 1'b0;
  endtask
  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) strobe(b[i]);
  endtask
  task automatic sel();
    @(negedge clk); #1 cs_n = 1'b0;
  endtask
  task automatic desel();
    @(negedge clk); #1 cs_n = 1'b1;
  endtask
  task automatic read_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); v[i] = so_bit;
      #1 si = 1'b0; sck_rise = 1'b1;
      @(negedge clk); #1 sck_rise = 1'b0;
    end
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 400 && wip; i++) @(negedge clk);
  endtask
  task automatic read_status(output logic [7:0] v);
    sel(); send_byte(8'h05); read_byte(v); desel();
  endtask
  task automatic write_status(logic [7:0] d);
    sel(); send_byte(8'h01); send_byte(d); desel();
    @(negedge clk);
    wait_idle();
  endtask

  initial begin
    logic [7:0] v, v2;
    int len;
    repeat (3) @(negedge clk);
    cmp_on = 1;
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 wip", int'(wip), 0);
    chk("R1 so_en", int'(so_en), 0);
    chk("R1 clr", int'(pgm_en_clr), 0);
    chk_addr = 9'd0;   #1 chk("R1 lock lo", int'(chk_locked), 0);
    chk_addr = 9'd511; #1 chk("R1 lock hi", int'(chk_locked), 0);

    // R2, R3 read twice across the wrap
    sel(); send_byte(8'h05);
    @(negedge clk); chk("R2 so_en", int'(so_en), 1);
    read_byte(v); read_byte(v2); desel();
    chk("R2 status", v, 8'h00); chk("R3 wrap", v2, 8'h00);

    // R5, R8 write with high bits set, measure busy length
    pgm_en = 1'b1;
    sel(); send_byte(8'h01); send_byte(8'hFB); desel();
    @(negedge clk); chk("R5 wip rise", int'(wip), 1);
    len = 0;
    while (wip && len < 400) begin len++; @(negedge clk); end
    chk("R5 wip length", len, WRC);
    chk("R5 clr pulses", clr_seen, 1);
    read_status(v); chk("R8 upper dropped", v, 8'h03);

    // R4 read during a write, straddling its end
    write_status(8'h02);
    sel(); send_byte(8'h01); send_byte(8'h05); desel();
    sel(); send_byte(8'h05); read_byte(v); read_byte(v2); read_byte(v2); desel();
    chk("R4 forced ones", v, 8'hFF);
    chk("R4 after end", v2, 8'h05);
    wait_idle();

    // R7 ignored frames
    pgm_en = 1'b0; write_status(8'h01); read_status(v); chk("R7 no enable", v, 8'h05);
    pgm_en = 1'b1;
    sel(); send_byte(8'h01); desel(); repeat (3) @(negedge clk);
    chk("R7 opcode only", int'(wip), 0);
    sel(); send_byte(8'h01); send_byte(8'h06); strobe(1'b0); strobe(1'b1); strobe(1'b0); desel();
    repeat (3) @(negedge clk);
    chk("R7 mid byte", int'(wip), 0);
    read_status(v); chk("R7 code kept", v, 8'h05);
    ext_wip = 1'b1;
    sel(); send_byte(8'h01); send_byte(8'h07); desel();
    ext_wip = 1'b0; repeat (3) @(negedge clk);
    read_status(v); chk("R7 busy at opcode", v, 8'h05);
    ext_wip = 1'b1; read_status(v); chk("R4 ext busy", v, 8'hFF); ext_wip = 1'b0;

    // R6 last byte wins
    sel(); send_byte(8'h01); send_byte(8'h02); send_byte(8'h05); send_byte(8'h04); desel();
    @(negedge clk); wait_idle();
    read_status(v); chk("R6 last byte", v, 8'h04);

    // R10 unknown opcode
    sel(); send_byte(8'h03); send_byte(8'h01); send_byte(8'h07);
    @(negedge clk); chk("R10 no output", int'(so_en), 0); desel();
    repeat (3) @(negedge clk);
    chk("R10 no write", int'(wip), 0);
    read_status(v); chk("R10 code kept", v, 8'h04);

    // R9 full sweep for every code
    for (int c = 0; c < 8; c++) begin
      write_status(8'(c));
      for (int a = 0; a < 512; a++) begin
        @(negedge clk); #1 chk_addr = 9'(a);
        #1 chk("R9 sweep", int'(chk_locked), ref_lock(c, a));
      end
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule